// File: doc/BRIEF.md
# SPI Slave Register Bank

This block is an SPI target that turns fixed 16-bit frames into accesses on a 16-entry register space. The lower half of the address space is eight byte-wide configuration registers. Their contents drive user logic through a single flat output bus. The upper half reads eight byte-wide status values that user logic presents on a flat input bus.

The serial clock, chip select and serial data-in pins are resynchronised into the system clock, and edges are found by oversampling. The system clock must therefore run at least four times faster than the serial clock. Two static mode pins set the clock idle level and the sampling phase, which gives all four SPI modes at run time.

The data path is the serial link itself, so there is no valid/ready interface. A frame has no back-pressure: the host owns the pace, and each frame is complete in itself.

Top module: `spi_regbank`

## Requirements
- R1: A frame is the bits clocked while `cs_n` is low, most significant first. Bit 15 is the command: 1 writes and 0 reads. Bits 11:8 are the address, bits 7:0 are the write data, and bits 14:12 are ignored.
- R2: When `cpol` is 0 the serial clock idles low, and when it is 1 the clock idles high. When `cpha` is 0 both sides sample on the first edge of each bit; when it is 1 they sample on the second edge. All four combinations work.
- R3: A write takes effect when `cs_n` rises, and only if at least 16 bits were clocked. A shorter frame changes nothing. Clocks after the 16th bit are ignored.
- R4: The configuration registers reset to zero. Register i appears on `cfg_out[8*i+7:8*i]`.
- R5: A write to an address from 8 to 15 changes no register.
- R6: `miso` is 0 for all 16 bits of a write frame.
- R7: In a read frame, `miso` is 0 for bits 15:8 and then carries the addressed byte, MSB first, in bits 7:0. The data bits on `mosi` have no effect.
- R8: A read of address 0 to 7 returns the configuration register. A read of address a from 8 to 15 returns `status_in[8*(a-8)+7:8*(a-8)]`.
- R9: The read byte is captured when the last address bit is sampled. Later changes on `status_in` do not alter the byte being shifted out.
- R10: `miso` is 0 while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Sampling phase: 0 samples on the leading edge, 1 on the trailing edge |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| status_in | input | 64 | Eight status bytes, byte i on bits 8i+7:8i |
| cfg_out | output | 64 | Eight configuration bytes, byte i on bits 8i+7:8i |

## Verification
The bench runs the same traffic in every clock mode, because a design that mixes up the sampling edge shifts every field by one bit and writes the wrong register. It sends a frame cut off before bit 16, which a design without the length check would commit with partial data, and a 17-bit frame, which a design without saturation would misalign or drop. It writes to read-only addresses, which a design with incomplete decoding would alias onto a configuration register. It also flips `status_in` partway through a read, which exposes a design that shifts live data instead of a captured byte.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned NUM_CFG    = 8;
  localparam int unsigned NUM_STAT   = 8;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int unsigned HDR_BITS   = FRAME_BITS - DATA_W;
  localparam int unsigned SH_W       = ADDR_W + DATA_W;
  localparam int unsigned SEL_W      = $clog2(NUM_CFG);
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= rst_val;
      else if (s == 0) stage_q[s] <= d;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cpol,
  input  logic  cpha,
  input  logic  sclk_s,
  input  logic  cs_n_s,
  input  logic  mosi_s,
  input  byte_t rdata,
  output logic  rd_latch,
  output addr_t rd_addr,
  output logic  shifting,
  output logic  wr_en,
  output addr_t wr_addr,
  output byte_t wr_data,
  output logic  miso
);
  logic            sck_q, cs_q, cmd_wr;
  cnt_t            cnt;
  logic [SH_W-1:0] sh;

  // Normalise so the leading edge is always a rise.
  wire sck_n   = sclk_s ^ cpol;
  wire lead    = sck_n & ~sck_q;
  wire trail   = ~sck_n & sck_q;
  wire smp     = (cpha ? trail : lead) & ~cs_n_s;
  wire full    = (cnt == cnt_t'(FRAME_BITS));
  wire cs_rise = cs_n_s & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      cnt    <= '0;
      sh     <= '0;
      cmd_wr <= 1'b0;
    end else begin
      sck_q <= sck_n;
      cs_q  <= cs_n_s;
      if (cs_n_s) begin
        cnt <= '0;
      end else if (smp && !full) begin
        cnt <= cnt + cnt_t'(1);
        sh  <= {sh[SH_W-2:0], mosi_s};
        if (cnt == '0) cmd_wr <= mosi_s;
      end
    end
  end

  // Commit pulse one cycle after chip select is seen high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= cs_rise && full && cmd_wr;
      wr_addr <= sh[SH_W-1:DATA_W];
      wr_data <= sh[DATA_W-1:0];
    end
  end

  assign rd_latch = smp && (cnt == cnt_t'(HDR_BITS - 1));
  assign rd_addr  = {sh[ADDR_W-2:0], mosi_s};
  assign shifting = ~cs_n_s && (cnt >= cnt_t'(HDR_BITS));

  always_comb begin
    miso = 1'b0;
    if (!cs_n_s && !cmd_wr && cnt >= cnt_t'(HDR_BITS) && !full)
      miso = rdata[~cnt[$clog2(DATA_W)-1:0]];
  end

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && !$past(cs_n_s) && cnt != $past(cnt)) |-> (cnt == $past(cnt) + cnt_t'(1)));
  assert_miso_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !miso);
  assert_wr_full_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cnt) == cnt_t'(FRAME_BITS));
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs
  import spi_rb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  addr_t                      wr_addr,
  input  byte_t                      wr_data,
  input  logic                       rd_latch,
  input  addr_t                      rd_addr,
  input  logic                       shifting,
  input  logic [NUM_STAT*DATA_W-1:0] status_in,
  output logic [NUM_CFG*DATA_W-1:0]  cfg_out,
  output byte_t                      rdata
);
  byte_t cfg_q [NUM_CFG];
  byte_t rd_sel;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cfg_q[i] <= '0;
      else if (wr_en && wr_addr == addr_t'(i)) cfg_q[i] <= wr_data;
    end
    assign cfg_out[i*DATA_W +: DATA_W] = cfg_q[i];
  end

  always_comb begin
    if (rd_addr[ADDR_W-1])
      rd_sel = status_in[{rd_addr[SEL_W-1:0], 3'b000} +: DATA_W];
    else
      rd_sel = cfg_q[rd_addr[SEL_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata <= '0;
    else if (rd_latch) rdata <= rd_sel;
  end

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_out));
  assert_ro_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[ADDR_W-1]) |=> $stable(cfg_out));
  assert_rdata_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |=> $stable(rdata));
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_rb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpol,
  input  logic                       cpha,
  input  logic                       sclk,
  input  logic                       cs_n,
  input  logic                       mosi,
  output logic                       miso,
  input  logic [NUM_STAT*DATA_W-1:0] status_in,
  output logic [NUM_CFG*DATA_W-1:0]  cfg_out
);
  logic  cs_n_s, sclk_s, mosi_s;
  logic  rd_latch, shifting, wr_en;
  addr_t rd_addr, wr_addr;
  byte_t wr_data, rdata;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_val(3'b100),
    .d({cs_n, sclk, mosi}), .q({cs_n_s, sclk_s, mosi_s})
  );

  spi_rb_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
    .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s), .rdata(rdata),
    .rd_latch(rd_latch), .rd_addr(rd_addr), .shifting(shifting),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .miso(miso)
  );

  spi_rb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_latch(rd_latch), .rd_addr(rd_addr),
    .shifting(shifting), .status_in(status_in), .cfg_out(cfg_out),
    .rdata(rdata)
  );
endmodule

// File: tb/test_spi_regbank.sv
module test_spi_regbank;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpol = 1'b0, cpha = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [63:0] status_in, cfg_out;
  logic [7:0]  cfg_m [8];
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_regbank i_spi_regbank (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .miso(miso), .status_in(status_in), .cfg_out(cfg_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_cfg();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = cfg_m[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    return a[3] ? status_in[a[2:0]*8 +: 8] : cfg_m[a[2:0]];
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cpol = m[1]; cpha = m[0]; sclk = m[1];
    repeat (3) @(negedge clk);
  endtask

  // Host side: nbits clocks, MISO captured at each sampling edge.
  task automatic xfer(input logic [15:0] w, input int nbits, input int chg_at, output logic [15:0] r);
    r = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 16) ? w[15-i] : 1'b1;
      if (!cpha) begin
        mosi = b; repeat (4) @(negedge clk);
        if (i < 16) r[15-i] = miso;
        sclk = ~sclk; repeat (4) @(negedge clk);
        sclk = ~sclk;
      end else begin
        sclk = ~sclk; mosi = b; repeat (4) @(negedge clk);
        if (i < 16) r[15-i] = miso;
        sclk = ~sclk; repeat (4) @(negedge clk);
      end
      if (i == chg_at) status_in = ~status_in;
    end
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input string req);
    logic [15:0] r;
    xfer({1'b1, 3'b101, a, d}, 16, -1, r);
    chk(r == 16'h0, "R6 miso low during write", 64'(r), 64'h0);
    if (!a[3]) cfg_m[a[2:0]] = d;
    chk(cfg_out == model_cfg(), req, cfg_out, model_cfg());
    chk(miso == 1'b0, "R10 miso idle", 64'(miso), 64'h0);
  endtask

  task automatic do_read(input logic [3:0] a, input logic [7:0] junk, input string req);
    logic [15:0] r;
    logic [7:0]  e;
    e = exp_read(a);
    xfer({1'b0, 3'b010, a, junk}, 16, -1, r);
    chk(r == {8'h00, e}, req, 64'(r), 64'({8'h00, e}));
    chk(cfg_out == model_cfg(), "R7 read leaves registers", cfg_out, model_cfg());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  e;
    void'($urandom(32'd4242));
    status_in = {8'h5A, 8'h66, 8'h10, 8'hC4, 8'h3C, 8'h81, 8'hE7, 8'h19};
    for (int i = 0; i < 8; i++) cfg_m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cfg_out == 64'h0, "R4 reset value", cfg_out, 64'h0);
    chk(miso == 1'b0, "R10 miso idle after reset", 64'(miso), 64'h0);

    // R2: every mode, write then read back
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      do_write(4'(m), 8'hA0 + 8'(m * 17), "R2 R1 write per mode");
      do_read(4'(m), 8'hFF, "R2 R8 read per mode");
      do_read(4'(12 + m), 8'h00, "R8 status read per mode");
    end

    // R5: read-only addresses take no write
    set_mode(2'b00);
    do_write(4'd9, 8'h77, "R5 write to status address ignored");
    do_write(4'd15, 8'hEE, "R5 write to top address ignored");
    do_read(4'd9, 8'h00, "R5 status read unchanged");

    // R3: short frame discarded, long frame keeps first 16 bits
    set_mode(2'b11);
    xfer({1'b1, 3'b000, 4'd5, 8'h3D}, 12, -1, r);
    chk(cfg_out == model_cfg(), "R3 short frame discarded", cfg_out, model_cfg());
    xfer({1'b1, 3'b000, 4'd6, 8'h4B}, 17, -1, r);
    cfg_m[6] = 8'h4B;
    chk(cfg_out == model_cfg(), "R3 extra clock ignored", cfg_out, model_cfg());

    // R9: status changes during the data phase do not reach MISO
    set_mode(2'b01);
    e = status_in[3*8 +: 8];
    xfer({1'b0, 3'b000, 4'd11, 8'h00}, 16, 9, r);
    chk(r == {8'h00, e}, "R9 read byte captured at address", 64'(r), 64'({8'h00, e}));
    set_mode(2'b10);
    e = status_in[6*8 +: 8];
    xfer({1'b0, 3'b000, 4'd14, 8'h00}, 16, 11, r);
    chk(r == {8'h00, e}, "R9 capture mode 2", 64'(r), 64'({8'h00, e}));

    // Random traffic
    for (int k = 0; k < 60; k++) begin
      logic [3:0] a;
      logic [7:0] d;
      set_mode(2'($urandom_range(0, 3)));
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) do_write(a, d, "R4 R1 random write");
      else                           do_read(a, d, "R7 R8 random read");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule